// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block sits on the host side of a system management bus. It takes one transaction request at a time and expands it into the series of byte-level actions that the bus needs: start, repeated start, byte write, byte read, and stop. A separate byte engine, outside this block, carries out each action. The engine reports completion, reports whether the target acknowledged each byte the host wrote, and returns each byte it read. Bit timing on the clock and data wires, and packet error checking, belong to other blocks.

A request gives a protocol type, a 7-bit target address, a command byte, a write length and up to `MAX_LEN` bytes of write data. When the sequence ends, the block raises `done` for one cycle. At that point `status`, `rd_count` and `rd_data` describe the result. Read data is stored from the first byte received upward. Block reads take their length from the count byte that the target returns.

Protocol type codes: 0 quick, 1 send byte, 2 receive byte, 3 write byte, 4 read byte, 5 write word, 6 read word, 7 process call, 8 block write, 9 block read, 10 block process call, 11 raw block write, 12 raw block read. Codes 13 to 15 are invalid.

Top module: `smb_host_seq`

## Requirements
- R1: A request is taken only in a cycle where `req_ready` is 1. A request raised while a sequence is running is ignored. The first engine action of every sequence is start. Each address byte is `{addr, dir}`, with dir 1 for read and 0 for write.
- R2: Engine action codes are 1 start, 2 repeated start, 3 write, 4 read and 5 stop. At most one action is outstanding. The next action is issued only after `eng_done`.
- R3: Quick (type 0) issues start, then the address byte with `req_wdata[0]` as the direction bit, then stop.
- R4: Send byte (type 1) writes `req_cmd` as its only byte after the address. Receive byte (type 2) addresses with dir 1 and reads one byte.
- R5: Read byte, read word and process call (types 4, 6, 7) write the command, then issue a repeated start, then the address with dir 1, then the reads. Every read byte is acked except the last, which is nacked before the stop (`eng_rack` 1 means ack).
- R6: Word data is written low byte first (`req_wdata[7:0]` first). The first word byte read lands in `rd_data[7:0]`.
- R7: Block write (type 8) writes a count byte equal to `req_len`, then that many data bytes. Block read (type 9) takes the data length from the first byte it reads. That byte is valid from 1 to `MAX_LEN`. The data goes to `rd_data`, and the length goes to `rd_count`.
- R8: Block process call (type 10) writes a count byte and 1 to `MAX_LEN-1` data bytes. It then issues a repeated start and reads a count byte, which must also lie in 1 to `MAX_LEN-1`, followed by that many bytes.
- R9: Raw block write and read (types 11, 12) carry no count byte. Their length is `req_len`, from 1 to `MAX_LEN`.
- R10: A nack on any byte the host writes makes the next action a stop. The status is then 1.
- R11: If a returned count is out of range, the block issues one more read with a nack, then a stop. The status is then 2.
- R12: An invalid type, or a length outside the range its type allows, causes no bus action. The request completes with status 3.
- R13: `done` is a single-cycle pulse, raised the cycle after the stop completes. Status 0 means success. `req_ready` returns on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Idle, a request will be taken |
| req_proto | input | 4 | Protocol type code |
| req_addr | input | 7 | Target address |
| req_cmd | input | 8 | Command byte, or the data byte for send byte |
| req_len | input | LEN_W | Write length, or raw read length |
| req_wdata | input | MAX_LEN*8 | Write bytes, byte 0 in the low bits |
| done | output | 1 | Completion pulse |
| status | output | 2 | 0 ok, 1 nack, 2 bad count, 3 bad request |
| rd_count | output | LEN_W | Number of bytes read into rd_data |
| rd_data | output | MAX_LEN*8 | Read bytes, first received in the low bits |
| eng_valid | output | 1 | Issue an engine action |
| eng_op | output | 3 | Engine action code |
| eng_wbyte | output | 8 | Byte to write |
| eng_rack | output | 1 | For reads: 1 ack, 0 nack |
| eng_done | input | 1 | Engine action finished |
| eng_ack | input | 1 | Target acknowledged the written byte |
| eng_rbyte | input | 8 | Byte read by the engine |

## Verification
The bench builds the block with `MAX_LEN` set to 8, which makes `LEN_W` 4. This keeps every length boundary cheap to reach. It covers a full block read of 8 bytes and a returned count of 9. It also covers a block process call count of 8, which exceeds the limit of 7. A request length of 0 or 8 is checked against the range of each type. A bench model of the byte engine records every action and injects nacks at chosen write positions.

// File: rtl/smb_seq_pkg.sv
package smb_seq_pkg;

    typedef enum logic [3:0] {
        P_QUICK = 4'd0,
        P_SEND  = 4'd1,
        P_RECV  = 4'd2,
        P_WRB   = 4'd3,
        P_RDB   = 4'd4,
        P_WRW   = 4'd5,
        P_RDW   = 4'd6,
        P_PCALL = 4'd7,
        P_BWR   = 4'd8,
        P_BRD   = 4'd9,
        P_BPC   = 4'd10,
        P_IWR   = 4'd11,
        P_IRD   = 4'd12
    } proto_e;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_START  = 3'd1,
        OP_RSTART = 3'd2,
        OP_WRITE  = 3'd3,
        OP_READ   = 3'd4,
        OP_STOP   = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        ST_OK     = 2'd0,
        ST_NACK   = 2'd1,
        ST_PROTO  = 2'd2,
        ST_BADREQ = 2'd3
    } stat_e;

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_ADDR1, S_CMD, S_WCNT, S_WDAT, S_RSTART,
        S_ADDR2, S_RCNT, S_RDAT, S_DRAIN, S_STOP, S_FIN
    } seq_e;

endpackage

// File: rtl/smb_len_chk.sv
module smb_len_chk
    import smb_seq_pkg::*;
#(
    parameter int unsigned MAX_LEN = 32,
    parameter int unsigned LEN_W   = 6
) (
    input  logic [3:0]       req_proto,
    input  logic [LEN_W-1:0] req_len,
    input  logic [3:0]       cur_proto,
    input  logic [7:0]       rx_cnt,
    output logic             req_ok,
    output logic             cnt_ok
);
    localparam int unsigned LIM_PC = MAX_LEN - 1;

    logic len_full;
    logic len_pc;

    always_comb begin
        len_full = (req_len != '0) && (32'(req_len) <= MAX_LEN);
        len_pc   = (req_len != '0) && (32'(req_len) <= LIM_PC);
        case (proto_e'(req_proto))
            P_QUICK, P_SEND, P_RECV, P_WRB, P_RDB,
            P_WRW, P_RDW, P_PCALL, P_BRD:  req_ok = 1'b1;
            P_BWR, P_IWR, P_IRD:           req_ok = len_full;
            P_BPC:                         req_ok = len_pc;
            default:                       req_ok = 1'b0;
        endcase
    end

    always_comb begin
        if (proto_e'(cur_proto) == P_BPC) begin
            cnt_ok = (rx_cnt != 8'd0) && (32'(rx_cnt) <= LIM_PC);
        end else begin
            cnt_ok = (rx_cnt != 8'd0) && (32'(rx_cnt) <= MAX_LEN);
        end
    end

endmodule

// File: rtl/smb_rd_store.sv
module smb_rd_store #(
    parameter int unsigned MAX_LEN = 32,
    parameter int unsigned LEN_W   = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 wr_en,
    input  logic [LEN_W-1:0]     wr_idx,
    input  logic [7:0]           wr_byte,
    output logic [MAX_LEN*8-1:0] rd_data
);
    for (genvar k = 0; k < int'(MAX_LEN); k++) begin : g_byte
        logic [7:0] byte_d, byte_q;

        always_comb begin
            byte_d = byte_q;
            if (clr) begin
                byte_d = 8'd0;
            end else if (wr_en && (wr_idx == LEN_W'(k))) begin
                byte_d = wr_byte;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) byte_q <= 8'd0;
            else        byte_q <= byte_d;
        end

        assign rd_data[k*8 +: 8] = byte_q;
    end

endmodule

// File: rtl/smb_seq_fsm.sv
module smb_seq_fsm
    import smb_seq_pkg::*;
#(
    parameter int unsigned MAX_LEN = 32,
    parameter int unsigned LEN_W   = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [3:0]           req_proto,
    input  logic [6:0]           req_addr,
    input  logic [7:0]           req_cmd,
    input  logic [LEN_W-1:0]     req_len,
    input  logic [MAX_LEN*8-1:0] req_wdata,
    input  logic                 req_ok,
    input  logic                 cnt_ok,
    input  logic                 eng_done,
    input  logic                 eng_ack,
    input  logic [7:0]           eng_rbyte,
    output logic                 req_ready,
    output logic                 done,
    output logic [1:0]           status,
    output logic [LEN_W-1:0]     rd_count,
    output logic [3:0]           cur_proto,
    output logic                 eng_valid,
    output logic [2:0]           eng_op,
    output logic [7:0]           eng_wbyte,
    output logic                 eng_rack,
    output logic                 st_clr,
    output logic                 st_wr,
    output logic [LEN_W-1:0]     st_idx,
    output logic [7:0]           st_byte
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    typedef struct packed {
        seq_e                 st;
        logic                 busy;
        proto_e               proto;
        logic [6:0]           addr;
        logic [7:0]           cmd;
        logic [LEN_W-1:0]     len;
        logic [LEN_W-1:0]     idx;
        logic [LEN_W-1:0]     total;
        stat_e                stat;
        logic [LEN_W-1:0]     rcount;
        logic [MAX_LEN*8-1:0] wdata;
    } seq_t;

    seq_t q, d;
    op_e  op;
    logic is_wr;
    logic last_rd;

    function automatic logic [7:0] pick(input logic [MAX_LEN*8-1:0] w,
                                        input logic [LEN_W-1:0] i);
        logic [7:0] b;
        b = 8'd0;
        for (int k = 0; k < int'(MAX_LEN); k++) begin
            if (i == LEN_W'(k)) b = w[k*8 +: 8];
        end
        return b;
    endfunction

    // Action presented to the byte engine, decoded from the current state
    always_comb begin
        op        = OP_NONE;
        eng_wbyte = 8'd0;
        eng_rack  = 1'b0;
        last_rd   = (q.idx == (q.total - ONE));
        case (q.st)
            S_START:  op = OP_START;
            S_RSTART: op = OP_RSTART;
            S_ADDR1: begin
                op = OP_WRITE;
                if (q.proto == P_QUICK) eng_wbyte = {q.addr, q.wdata[0]};
                else                    eng_wbyte = {q.addr, q.proto == P_RECV};
            end
            S_ADDR2: begin
                op        = OP_WRITE;
                eng_wbyte = {q.addr, 1'b1};
            end
            S_CMD: begin
                op        = OP_WRITE;
                eng_wbyte = q.cmd;
            end
            S_WCNT: begin
                op        = OP_WRITE;
                eng_wbyte = 8'(q.len);
            end
            S_WDAT: begin
                op        = OP_WRITE;
                eng_wbyte = pick(q.wdata, q.idx);
            end
            S_RCNT: begin
                op       = OP_READ;
                eng_rack = 1'b1;
            end
            S_RDAT: begin
                op       = OP_READ;
                eng_rack = !last_rd;
            end
            S_DRAIN:  op = OP_READ;
            S_STOP:   op = OP_STOP;
            default:  op = OP_NONE;
        endcase
        is_wr     = (op == OP_WRITE);
        eng_valid = (op != OP_NONE) && !q.busy;
        eng_op    = 3'(op);
    end

    // Sequencing
    always_comb begin
        d      = q;
        st_clr = 1'b0;
        st_wr  = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    d.proto  = proto_e'(req_proto);
                    d.addr   = req_addr;
                    d.cmd    = req_cmd;
                    d.len    = req_len;
                    d.wdata  = req_wdata;
                    d.idx    = '0;
                    d.total  = '0;
                    d.rcount = '0;
                    d.busy   = 1'b0;
                    st_clr   = 1'b1;
                    if (req_ok) begin
                        d.st   = S_START;
                        d.stat = ST_OK;
                    end else begin
                        d.st   = S_FIN;
                        d.stat = ST_BADREQ;
                    end
                end
            end
            S_FIN: d.st = S_IDLE;
            default: begin
                if (!q.busy) begin
                    d.busy = 1'b1;
                end else if (eng_done) begin
                    d.busy = 1'b0;
                    d.idx  = '0;
                    if (is_wr && !eng_ack) begin
                        d.stat = ST_NACK;
                        d.st   = S_STOP;
                    end else begin
                        case (q.st)
                            S_START: d.st = S_ADDR1;
                            S_ADDR1: begin
                                case (q.proto)
                                    P_QUICK: d.st = S_STOP;
                                    P_RECV: begin
                                        d.st    = S_RDAT;
                                        d.total = ONE;
                                    end
                                    default: d.st = S_CMD;
                                endcase
                            end
                            S_CMD: begin
                                case (q.proto)
                                    P_SEND: d.st = S_STOP;
                                    P_WRB: begin
                                        d.st    = S_WDAT;
                                        d.total = ONE;
                                    end
                                    P_WRW, P_PCALL: begin
                                        d.st    = S_WDAT;
                                        d.total = LEN_W'(2);
                                    end
                                    P_IWR: begin
                                        d.st    = S_WDAT;
                                        d.total = q.len;
                                    end
                                    P_BWR, P_BPC: begin
                                        d.st    = S_WCNT;
                                        d.total = q.len;
                                    end
                                    default: d.st = S_RSTART;
                                endcase
                            end
                            S_WCNT: d.st = S_WDAT;
                            S_WDAT: begin
                                d.idx = q.idx + ONE;
                                if (q.idx == (q.total - ONE)) begin
                                    d.idx = '0;
                                    if ((q.proto == P_PCALL) || (q.proto == P_BPC)) d.st = S_RSTART;
                                    else                                            d.st = S_STOP;
                                end
                            end
                            S_RSTART: d.st = S_ADDR2;
                            S_ADDR2: begin
                                case (q.proto)
                                    P_BRD, P_BPC: d.st = S_RCNT;
                                    P_RDW, P_PCALL: begin
                                        d.st    = S_RDAT;
                                        d.total = LEN_W'(2);
                                    end
                                    P_IRD: begin
                                        d.st    = S_RDAT;
                                        d.total = q.len;
                                    end
                                    default: begin
                                        d.st    = S_RDAT;
                                        d.total = ONE;
                                    end
                                endcase
                            end
                            S_RCNT: begin
                                if (cnt_ok) begin
                                    d.st    = S_RDAT;
                                    d.total = eng_rbyte[LEN_W-1:0];
                                end else begin
                                    d.st   = S_DRAIN;
                                    d.stat = ST_PROTO;
                                end
                            end
                            S_RDAT: begin
                                st_wr    = 1'b1;
                                d.rcount = q.idx + ONE;
                                d.idx    = q.idx + ONE;
                                if (last_rd) d.st = S_STOP;
                            end
                            S_DRAIN: d.st = S_STOP;
                            S_STOP:  d.st = S_FIN;
                            default: d.st = S_IDLE;
                        endcase
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= S_IDLE;
            q.stat  <= ST_OK;
            q.proto <= P_QUICK;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == S_IDLE);
    assign done      = (q.st == S_FIN);
    assign status    = q.stat;
    assign rd_count  = q.rcount;
    assign cur_proto = q.proto;
    assign st_idx    = q.idx;
    assign st_byte   = eng_rbyte;

endmodule

// File: rtl/smb_host_seq.sv
module smb_host_seq
    import smb_seq_pkg::*;
#(
    parameter int unsigned MAX_LEN = 32,
    localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [3:0]           req_proto,
    input  logic [6:0]           req_addr,
    input  logic [7:0]           req_cmd,
    input  logic [LEN_W-1:0]     req_len,
    input  logic [MAX_LEN*8-1:0] req_wdata,
    output logic                 done,
    output logic [1:0]           status,
    output logic [LEN_W-1:0]     rd_count,
    output logic [MAX_LEN*8-1:0] rd_data,
    output logic                 eng_valid,
    output logic [2:0]           eng_op,
    output logic [7:0]           eng_wbyte,
    output logic                 eng_rack,
    input  logic                 eng_done,
    input  logic                 eng_ack,
    input  logic [7:0]           eng_rbyte
);
    logic             req_ok, cnt_ok;
    logic [3:0]       cur_proto;
    logic             st_clr, st_wr;
    logic [LEN_W-1:0] st_idx;
    logic [7:0]       st_byte;

    smb_len_chk #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_len (
        .req_proto (req_proto),
        .req_len   (req_len),
        .cur_proto (cur_proto),
        .rx_cnt    (eng_rbyte),
        .req_ok    (req_ok),
        .cnt_ok    (cnt_ok)
    );

    smb_seq_fsm #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_proto (req_proto),
        .req_addr  (req_addr),
        .req_cmd   (req_cmd),
        .req_len   (req_len),
        .req_wdata (req_wdata),
        .req_ok    (req_ok),
        .cnt_ok    (cnt_ok),
        .eng_done  (eng_done),
        .eng_ack   (eng_ack),
        .eng_rbyte (eng_rbyte),
        .req_ready (req_ready),
        .done      (done),
        .status    (status),
        .rd_count  (rd_count),
        .cur_proto (cur_proto),
        .eng_valid (eng_valid),
        .eng_op    (eng_op),
        .eng_wbyte (eng_wbyte),
        .eng_rack  (eng_rack),
        .st_clr    (st_clr),
        .st_wr     (st_wr),
        .st_idx    (st_idx),
        .st_byte   (st_byte)
    );

    smb_rd_store #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (st_clr),
        .wr_en   (st_wr),
        .wr_idx  (st_idx),
        .wr_byte (st_byte),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/smb_host_seq_chk.sv
module smb_host_seq_chk
    import smb_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       eng_valid,
    input logic [2:0] eng_op,
    input logic       eng_done,
    input logic       eng_ack,
    input logic       done,
    input logic [1:0] status
);
    logic       pend_q;
    logic       first_q;
    logic       nack_q;
    logic [2:0] last_op_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            first_q   <= 1'b0;
            nack_q    <= 1'b0;
            last_op_q <= 3'd0;
        end else begin
            if (eng_valid)     pend_q <= 1'b1;
            else if (eng_done) pend_q <= 1'b0;
            if (eng_valid) last_op_q <= eng_op;
            if (req_valid && req_ready) first_q <= 1'b1;
            else if (eng_valid)         first_q <= 1'b0;
            if (eng_valid) nack_q <= 1'b0;
            else if (eng_done && !eng_ack && (last_op_q == 3'(OP_WRITE))) nack_q <= 1'b1;
        end
    end

    a_r2_single_op: assert property (@(posedge clk) disable iff (!rst_n)
        eng_valid |-> !pend_q);

    a_r1_start_first: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid && first_q) |-> (eng_op == 3'(OP_START)));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !eng_valid);

    a_r10_stop_after_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid && nack_q) |-> (eng_op == 3'(OP_STOP)));

    a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r13_done_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (status != 2'(ST_BADREQ))) |-> ((last_op_q == 3'(OP_STOP)) && !pend_q));

endmodule

bind smb_host_seq smb_host_seq_chk u_chk (.*);

// File: tb/tb_smb_host_seq.sv
`timescale 1ns/1ps
module tb_smb_host_seq;
    localparam int ML = 8;
    localparam int LW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [3:0]      req_proto = '0;
    logic [6:0]      req_addr = '0;
    logic [7:0]      req_cmd = '0;
    logic [LW-1:0]   req_len = '0;
    logic [ML*8-1:0] req_wdata = '0;
    logic            done;
    logic [1:0]      status;
    logic [LW-1:0]   rd_count;
    logic [ML*8-1:0] rd_data;
    logic            eng_valid;
    logic [2:0]      eng_op;
    logic [7:0]      eng_wbyte;
    logic            eng_rack;
    logic            eng_done = 1'b0;
    logic            eng_ack = 1'b0;
    logic [7:0]      eng_rbyte = '0;

    always #2 clk = ~clk;

    smb_host_seq #(.MAX_LEN(ML)) dut (.*);

    int n_run = 0;
    int n_fail = 0;

    // byte engine model and action log
    logic [11:0] log_q [64];
    logic [11:0] exp_q [64];
    int          log_n = 0;
    int          exp_n = 0;
    logic [7:0]  rd_src [16];
    int          rd_ptr = 0;
    int          wr_cnt = 0;
    int          nack_at = -1;
    logic [2:0]  m_op;
    logic [7:0]  m_wb, m_rb;
    logic        m_ra, m_ack;

    always begin
        @(negedge clk);
        while (eng_valid) begin
            m_op = eng_op; m_wb = eng_wbyte; m_ra = eng_rack;
            m_ack = 1'b1; m_rb = 8'h00;
            if (m_op == 3'd3) begin
                m_ack = (wr_cnt != nack_at);
                wr_cnt++;
            end
            if (m_op == 3'd4) begin
                m_rb = (rd_ptr < 16) ? rd_src[rd_ptr] : 8'hFF;
                rd_ptr++;
            end
            if (log_n < 64)
                log_q[log_n] = {m_op, (m_op == 3'd4) ? m_ra : 1'b0,
                                (m_op == 3'd3) ? m_wb : m_rb};
            log_n++;
            repeat (2) @(negedge clk);
            eng_done = 1'b1; eng_ack = m_ack; eng_rbyte = m_rb;
            @(negedge clk);
            eng_done = 1'b0;
        end
    end

    logic [1:0]      r_stat;
    logic [LW-1:0]   r_cnt;
    logic [ML*8-1:0] r_data;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic e_add(input logic [2:0] op, input logic r, input logic [7:0] b);
        exp_q[exp_n] = {op, r, b};
        exp_n++;
    endtask
    task automatic e_s();  e_add(3'd1, 1'b0, 8'h00); endtask
    task automatic e_rs(); e_add(3'd2, 1'b0, 8'h00); endtask
    task automatic e_p();  e_add(3'd5, 1'b0, 8'h00); endtask
    task automatic e_w(input logic [7:0] b); e_add(3'd3, 1'b0, b); endtask
    task automatic e_r(input logic [7:0] b, input logic a); e_add(3'd4, a, b); endtask

    task automatic check_log(input string tag);
        int bad;
        bad = -1;
        chk(log_n == exp_n, {tag, " action count"}, 64'(log_n), 64'(exp_n));
        for (int i = 0; i < exp_n && i < log_n && i < 64; i++)
            if (bad < 0 && log_q[i] !== exp_q[i]) bad = i;
        chk(bad < 0, {tag, " action sequence"},
            (bad < 0) ? 64'd0 : 64'(log_q[bad]), (bad < 0) ? 64'd0 : 64'(exp_q[bad]));
    endtask

    task automatic run_txn(input logic [3:0] p, input logic [6:0] a, input logic [7:0] c,
                           input logic [LW-1:0] l, input logic [ML*8-1:0] w);
        bit got;
        log_n = 0; wr_cnt = 0; rd_ptr = 0; exp_n = 0; got = 0;
        @(negedge clk);
        req_proto = p; req_addr = a; req_cmd = c; req_len = l; req_wdata = w;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (done) begin
                got = 1; r_stat = status; r_cnt = rd_count; r_data = rd_data;
                break;
            end
            @(negedge clk);
        end
        chk(got, "R13 done raised", 64'(got), 64'd1);
        nack_at = -1;
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R13 ready after reset", 64'(req_ready), 64'd1);
        chk(done == 1'b0, "R13 no done after reset", 64'(done), 64'd0);
        chk(eng_valid == 1'b0, "R2 no action after reset", 64'(eng_valid), 64'd0);
    endtask

    task automatic t_quick();
        run_txn(4'd0, 7'h2A, 8'h00, '0, 64'h1);
        e_s(); e_w(8'h55); e_p();
        check_log("R3 quick");
        chk(r_stat == 2'd0, "R3 quick status", 64'(r_stat), 64'd0);
    endtask

    task automatic t_send_recv();
        run_txn(4'd1, 7'h10, 8'hA5, '0, '0);
        e_s(); e_w(8'h20); e_w(8'hA5); e_p();
        check_log("R4 send byte");
        rd_src[0] = 8'h3C;
        run_txn(4'd2, 7'h10, 8'h00, '0, '0);
        e_s(); e_w(8'h21); e_r(8'h3C, 1'b0); e_p();
        check_log("R4 receive byte");
        chk(r_data[7:0] == 8'h3C && r_cnt == 4'd1, "R4 receive data", 64'(r_data[7:0]), 64'h3C);
    endtask

    task automatic t_words();
        run_txn(4'd3, 7'h50, 8'h06, '0, 64'h5A);
        e_s(); e_w(8'hA0); e_w(8'h06); e_w(8'h5A); e_p();
        check_log("R6 write byte");
        run_txn(4'd5, 7'h50, 8'h07, '0, 64'hBEEF);
        e_s(); e_w(8'hA0); e_w(8'h07); e_w(8'hEF); e_w(8'hBE); e_p();
        check_log("R6 write word low first");
        rd_src[0] = 8'h34; rd_src[1] = 8'h12;
        run_txn(4'd6, 7'h50, 8'h08, '0, '0);
        e_s(); e_w(8'hA0); e_w(8'h08); e_rs(); e_w(8'hA1);
        e_r(8'h34, 1'b1); e_r(8'h12, 1'b0); e_p();
        check_log("R5 read word");
        chk(r_data[15:0] == 16'h1234, "R6 read word order", 64'(r_data[15:0]), 64'h1234);
        chk(r_cnt == 4'd2, "R6 read word count", 64'(r_cnt), 64'd2);
        rd_src[0] = 8'h9C;
        run_txn(4'd4, 7'h50, 8'h09, '0, '0);
        e_s(); e_w(8'hA0); e_w(8'h09); e_rs(); e_w(8'hA1); e_r(8'h9C, 1'b0); e_p();
        check_log("R5 read byte");
    endtask

    task automatic t_pcall();
        rd_src[0] = 8'hAA; rd_src[1] = 8'hBB;
        run_txn(4'd7, 7'h11, 8'h01, '0, 64'h5678);
        e_s(); e_w(8'h22); e_w(8'h01); e_w(8'h78); e_w(8'h56); e_rs(); e_w(8'h23);
        e_r(8'hAA, 1'b1); e_r(8'hBB, 1'b0); e_p();
        check_log("R5 process call");
        chk(r_data[15:0] == 16'hBBAA, "R5 process call data", 64'(r_data[15:0]), 64'hBBAA);
    endtask

    task automatic t_block();
        logic [ML*8-1:0] ex;
        run_txn(4'd8, 7'h12, 8'h40, 4'd3, 64'h332211);
        e_s(); e_w(8'h24); e_w(8'h40); e_w(8'h03); e_w(8'h11); e_w(8'h22); e_w(8'h33); e_p();
        check_log("R7 block write");
        rd_src[0] = 8'd8;
        for (int k = 0; k < 8; k++) rd_src[k+1] = 8'h81 + 8'(k);
        run_txn(4'd9, 7'h12, 8'h41, '0, '0);
        e_s(); e_w(8'h24); e_w(8'h41); e_rs(); e_w(8'h25); e_r(8'd8, 1'b1);
        for (int k = 0; k < 8; k++) e_r(8'h81 + 8'(k), k != 7);
        e_p();
        check_log("R7 block read full length");
        for (int k = 0; k < 8; k++) ex[k*8 +: 8] = 8'h81 + 8'(k);
        chk(r_data == ex, "R7 block read data", 64'(r_data), 64'(ex));
        chk(r_cnt == 4'd8 && r_stat == 2'd0, "R7 block read count", 64'(r_cnt), 64'd8);
    endtask

    task automatic t_badcount();
        rd_src[0] = 8'd9; rd_src[1] = 8'hEE;
        run_txn(4'd9, 7'h12, 8'h42, '0, '0);
        e_s(); e_w(8'h24); e_w(8'h42); e_rs(); e_w(8'h25); e_r(8'd9, 1'b1); e_r(8'hEE, 1'b0); e_p();
        check_log("R11 count above limit");
        chk(r_stat == 2'd2, "R11 status count above limit", 64'(r_stat), 64'd2);
        rd_src[0] = 8'd0; rd_src[1] = 8'hED;
        run_txn(4'd9, 7'h12, 8'h43, '0, '0);
        e_s(); e_w(8'h24); e_w(8'h43); e_rs(); e_w(8'h25); e_r(8'd0, 1'b1); e_r(8'hED, 1'b0); e_p();
        check_log("R11 zero count");
        chk(r_stat == 2'd2 && r_cnt == 4'd0, "R11 status zero count", 64'(r_stat), 64'd2);
    endtask

    task automatic t_bpc();
        rd_src[0] = 8'd3; rd_src[1] = 8'hD1; rd_src[2] = 8'hD2; rd_src[3] = 8'hD3;
        run_txn(4'd10, 7'h13, 8'h55, 4'd2, 64'hC2C1);
        e_s(); e_w(8'h26); e_w(8'h55); e_w(8'h02); e_w(8'hC1); e_w(8'hC2); e_rs(); e_w(8'h27);
        e_r(8'd3, 1'b1); e_r(8'hD1, 1'b1); e_r(8'hD2, 1'b1); e_r(8'hD3, 1'b0); e_p();
        check_log("R8 block process call");
        chk(r_data[23:0] == 24'hD3D2D1 && r_cnt == 4'd3, "R8 block process call data",
            64'(r_data[23:0]), 64'hD3D2D1);
        rd_src[0] = 8'd8; rd_src[1] = 8'hE0;
        run_txn(4'd10, 7'h13, 8'h56, 4'd1, 64'hC3);
        chk(r_stat == 2'd2, "R8 returned count at MAX_LEN rejected", 64'(r_stat), 64'd2);
    endtask

    task automatic t_raw();
        run_txn(4'd11, 7'h14, 8'h66, 4'd2, 64'hA2A1);
        e_s(); e_w(8'h28); e_w(8'h66); e_w(8'hA1); e_w(8'hA2); e_p();
        check_log("R9 raw block write");
        rd_src[0] = 8'hE1; rd_src[1] = 8'hE2; rd_src[2] = 8'hE3;
        run_txn(4'd12, 7'h14, 8'h67, 4'd3, '0);
        e_s(); e_w(8'h28); e_w(8'h67); e_rs(); e_w(8'h29);
        e_r(8'hE1, 1'b1); e_r(8'hE2, 1'b1); e_r(8'hE3, 1'b0); e_p();
        check_log("R9 raw block read");
        chk(r_data[23:0] == 24'hE3E2E1, "R9 raw read data", 64'(r_data[23:0]), 64'hE3E2E1);
    endtask

    task automatic t_nack();
        nack_at = 1;
        run_txn(4'd3, 7'h50, 8'h06, '0, 64'h5A);
        e_s(); e_w(8'hA0); e_w(8'h06); e_p();
        check_log("R10 nack on command");
        chk(r_stat == 2'd1, "R10 status nack", 64'(r_stat), 64'd1);
        nack_at = 0;
        run_txn(4'd6, 7'h51, 8'h06, '0, '0);
        e_s(); e_w(8'hA2); e_p();
        check_log("R10 nack on address");
        chk(r_stat == 2'd1, "R10 status address nack", 64'(r_stat), 64'd1);
    endtask

    task automatic t_badreq();
        run_txn(4'd15, 7'h10, 8'h00, '0, '0);
        chk(log_n == 0 && r_stat == 2'd3, "R12 invalid type", 64'(log_n), 64'd0);
        run_txn(4'd8, 7'h10, 8'h00, 4'd0, '0);
        chk(log_n == 0 && r_stat == 2'd3, "R12 block write length 0", 64'(r_stat), 64'd3);
        run_txn(4'd10, 7'h10, 8'h00, 4'd8, '0);
        chk(log_n == 0 && r_stat == 2'd3, "R12 block process call length 8", 64'(r_stat), 64'd3);
        run_txn(4'd12, 7'h10, 8'h00, 4'd9, '0);
        chk(log_n == 0 && r_stat == 2'd3, "R12 raw read length 9", 64'(r_stat), 64'd3);
    endtask

    task automatic t_busy();
        int ops;
        log_n = 0; wr_cnt = 0; rd_ptr = 0; exp_n = 0;
        @(negedge clk);
        req_proto = 4'd0; req_addr = 7'h2B; req_wdata = '0; req_valid = 1'b1;
        @(negedge clk);
        req_proto = 4'd3; req_addr = 7'h33; req_cmd = 8'h77;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 3000 && !done; i++) @(negedge clk);
        chk(req_ready == 1'b0 && done == 1'b1, "R13 done while busy test", 64'(done), 64'd1);
        @(negedge clk);
        chk(req_ready == 1'b1 && done == 1'b0, "R13 done single pulse", 64'(done), 64'd0);
        ops = log_n;
        repeat (20) @(negedge clk);
        e_s(); e_w(8'h56); e_p();
        check_log("R1 request while busy ignored");
        chk(log_n == ops, "R1 no late action", 64'(log_n), 64'(ops));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog: actual hung expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_quick();
        t_send_recv();
        t_words();
        t_pcall();
        t_block();
        t_badcount();
        t_bpc();
        t_raw();
        t_nack();
        t_badreq();
        t_busy();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule